// File: doc/BRIEF.md
# Host Bridge I/O Cycle Router

This block sits in a host bridge and decides where each I/O cycle from the CPU goes. A few I/O locations belong to the bridge itself, and accesses to them stay inside the bridge:

- a 32-bit configuration address register;
- a four-byte configuration data window, which counts only while that register's enable bit is set;
- a one-byte power management control register.

An access to an address inside a programmable, inclusive base/limit window goes to the graphics port bus. Every other I/O cycle goes to the primary PCI bus.

The address reaches the destination unchanged. The block also produces the seventeenth address bit that a multi-byte access needs when it runs past 0FFFFh, so 64K+3 byte locations can be reached. The block also flags whether a write may be posted. Writes to the legacy disk controller command and control blocks are never posted.

Each cycle is given as a start address, a byte count code, a direction and a valid strobe. One clock later the block returns the following, with a qualifying strobe:

- a one-hot destination;
- a one-hot internal register select;
- the posting flag;
- the wrap bit;
- the forwarded address.

Configuration software writes the two window bounds through a separate write port.

Top module: `io_cycle_router`

## Requirements
- R1: After reset, out_valid_o, dst_o, int_sel_o and post_ok_o are 0. The window bounds reset to base FFFFh and limit 0000h, so the window is empty and no access goes to the graphics port.
- R2: The result of each cycle appears exactly one clock after cyc_valid_i, with out_valid_o high. dst_o is then one-hot: bit 0 means internal, bit 1 means PCI and bit 2 means graphics port. While out_valid_o is low, dst_o, int_sel_o and post_ok_o are 0.
- R3: An access whose start address lies in 0CF8h..0CFBh is internal, with int_sel_o = 001b. A write with size code 2 (four bytes) starting at 0CF8h loads the enable bit (bit 31) from cyc_wdata_msb_i. The new value takes effect from the next cycle.
- R4: An access starting in 0CFCh..0CFFh is internal with int_sel_o = 010b only while the enable bit is 1. Otherwise it is routed like any other address.
- R5: An access starting at 0022h (the power management control register) is internal, with int_sel_o = 100b.
- R6: A non-internal access is sent to the graphics port when base <= address <= limit, with both bounds inclusive. win_we_i with win_sel_i = 0 writes the base, and win_sel_i = 1 writes the limit; a written bound takes effect from the next cycle. When base > limit, nothing goes to the graphics port.
- R7: Any access that is neither internal nor inside the window is sent to PCI.
- R8: addr_o equals the start address unchanged. Size codes are 0 for one byte, 1 for two bytes, and 2 or 3 for four bytes. wrap_o is 1 for a four-byte access starting at FFFDh, FFFEh or FFFFh, and for a two-byte access starting at FFFFh. It is 0 for every other access.
- R9: post_ok_o is 1 only for a write forwarded to PCI or the graphics port whose start address lies outside 1F0h..1F7h, 3F6h, 170h..177h and 376h. It is 0 for reads and for internal accesses.
- R10: The internal registers take priority over the graphics window. An internal address stays internal even when the window covers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cyc_valid_i | input | 1 | An I/O cycle is presented this clock |
| cyc_addr_i | input | 16 | Start byte address of the cycle |
| cyc_size_i | input | 2 | Byte count code: 0 = 1, 1 = 2, 2 or 3 = 4 |
| cyc_write_i | input | 1 | 1 = write, 0 = read |
| cyc_wdata_msb_i | input | 1 | Bit 31 of the write data |
| win_we_i | input | 1 | Write strobe for a window bound |
| win_sel_i | input | 1 | 0 = base, 1 = limit |
| win_data_i | input | 16 | Bound value to write |
| out_valid_o | output | 1 | The routing result is valid |
| dst_o | output | 3 | One-hot destination {graphics, PCI, internal} |
| int_sel_o | output | 3 | One-hot internal register {power mgmt, config data, config address} |
| post_ok_o | output | 1 | The write may be posted |
| wrap_o | output | 1 | Seventeenth address bit |
| addr_o | output | 16 | Forwarded start address |

## Verification
The bench probes both bounds of the window and the addresses one past each bound. A comparator using an exclusive bound, or one with the bounds swapped, would route the edge addresses to the wrong bus. The bench also checks wrap detection at each start address and size that crosses 0FFFFh, plus neighbours that just fail to cross; an off-by-one end-address calculation would set the wrap bit on an access that stays below 10000h, or miss a genuine crossing. The bench turns the configuration enable on and off and places the window over the internal registers. A design that ignored the enable, applied it a cycle early, or let the window win over internal registers would misroute data-window accesses. Writes are sent to every edge of the disk controller ranges and just outside them, so a wrong range edge in the no-posting rule shows up as a wrong posting flag.

// File: rtl/io_rtr_pkg.sv
package io_rtr_pkg;
  localparam int AW    = 16;
  localparam int IDE_N = 4;

  typedef logic [AW-1:0] ioaddr_t;

  // ranges where writes must not be posted
  localparam ioaddr_t IDE_LO [IDE_N] = '{16'h01F0, 16'h03F6, 16'h0170, 16'h0376};
  localparam ioaddr_t IDE_HI [IDE_N] = '{16'h01F7, 16'h03F6, 16'h0177, 16'h0376};

  typedef enum logic [1:0] {
    SZ_1  = 2'd0,
    SZ_2  = 2'd1,
    SZ_4  = 2'd2,
    SZ_4X = 2'd3
  } io_size_e;

  typedef struct packed {
    logic gfx;
    logic pci;
    logic intl;
  } dst_t;

  // byte count minus one
  function automatic logic [1:0] size_span(input logic [1:0] sz);
    case (io_size_e'(sz))
      SZ_1:    return 2'd0;
      SZ_2:    return 2'd1;
      default: return 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/io_int_decode.sv
module io_int_decode
  import io_rtr_pkg::*;
#(
  parameter ioaddr_t PM_ADDR  = 16'h0022,
  parameter ioaddr_t CFA_ADDR = 16'h0CF8,
  parameter ioaddr_t CFD_ADDR = 16'h0CFC
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    valid_i,
  input  ioaddr_t addr_i,
  input  logic    [1:0] size_i,
  input  logic    write_i,
  input  logic    wdata_msb_i,
  output logic    hit_o,
  output logic    [2:0] sel_o
);
  localparam ioaddr_t CFA_END = CFA_ADDR + ioaddr_t'(3);
  localparam ioaddr_t CFD_END = CFD_ADDR + ioaddr_t'(3);

  logic cfg_en_q;
  logic cfa_hit, cfd_hit, pm_hit, cfa_load;

  assign cfa_hit  = (addr_i >= CFA_ADDR) && (addr_i <= CFA_END);
  assign cfd_hit  = cfg_en_q && (addr_i >= CFD_ADDR) && (addr_i <= CFD_END);
  assign pm_hit   = (addr_i == PM_ADDR);
  assign cfa_load = valid_i && write_i && (addr_i == CFA_ADDR) && size_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_en_q <= 1'b0;
    else if (cfa_load) cfg_en_q <= wdata_msb_i;
  end

  assign sel_o = {pm_hit, cfd_hit, cfa_hit};
  assign hit_o = |sel_o;
endmodule

// File: rtl/io_win_decode.sv
module io_win_decode
  import io_rtr_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    we_i,
  input  logic    sel_i,
  input  ioaddr_t data_i,
  input  ioaddr_t addr_i,
  output logic    hit_o
);
  ioaddr_t base_q, limit_q;

  // reset to an empty window: base above limit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '1;
      limit_q <= '0;
    end else if (we_i) begin
      if (sel_i) limit_q <= data_i;
      else       base_q  <= data_i;
    end
  end

  assign hit_o = (addr_i >= base_q) && (addr_i <= limit_q);
endmodule

// File: rtl/io_ide_match.sv
module io_ide_match
  import io_rtr_pkg::*;
(
  input  ioaddr_t addr_i,
  output logic    hit_o
);
  logic [IDE_N-1:0] rng_hit;

  for (genvar g = 0; g < IDE_N; g++) begin : g_rng
    assign rng_hit[g] = (addr_i >= IDE_LO[g]) && (addr_i <= IDE_HI[g]);
  end

  assign hit_o = |rng_hit;
endmodule

// File: rtl/io_cycle_router.sv
module io_cycle_router
  import io_rtr_pkg::*;
#(
  parameter logic [15:0] PM_ADDR = 16'h0022
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cyc_valid_i,
  input  logic [15:0] cyc_addr_i,
  input  logic [1:0]  cyc_size_i,
  input  logic        cyc_write_i,
  input  logic        cyc_wdata_msb_i,
  input  logic        win_we_i,
  input  logic        win_sel_i,
  input  logic [15:0] win_data_i,
  output logic        out_valid_o,
  output logic [2:0]  dst_o,
  output logic [2:0]  int_sel_o,
  output logic        post_ok_o,
  output logic        wrap_o,
  output logic [15:0] addr_o
);
  logic       int_hit, win_hit, ide_hit;
  logic [2:0] int_sel;
  dst_t       dst_d, dst_q;
  logic [AW:0] end_addr;
  logic       wrap_d, post_d;
  logic [2:0] int_sel_q;
  logic       post_q, wrap_q, valid_q;
  ioaddr_t    addr_q;

  io_int_decode #(.PM_ADDR(PM_ADDR)) i_int (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (cyc_valid_i),
    .addr_i      (cyc_addr_i),
    .size_i      (cyc_size_i),
    .write_i     (cyc_write_i),
    .wdata_msb_i (cyc_wdata_msb_i),
    .hit_o       (int_hit),
    .sel_o       (int_sel)
  );

  io_win_decode i_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (win_we_i),
    .sel_i  (win_sel_i),
    .data_i (win_data_i),
    .addr_i (cyc_addr_i),
    .hit_o  (win_hit)
  );

  io_ide_match i_ide (
    .addr_i (cyc_addr_i),
    .hit_o  (ide_hit)
  );

  // internal claims first, then the graphics window, then PCI
  always_comb begin
    dst_d.intl = int_hit;
    dst_d.gfx  = !int_hit && win_hit;
    dst_d.pci  = !int_hit && !win_hit;
  end

  assign end_addr = {1'b0, cyc_addr_i} + {{(AW-1){1'b0}}, size_span(cyc_size_i)};
  assign wrap_d   = end_addr[AW];
  assign post_d   = cyc_write_i && !int_hit && !ide_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      dst_q     <= '0;
      int_sel_q <= '0;
      post_q    <= 1'b0;
      wrap_q    <= 1'b0;
      addr_q    <= '0;
    end else begin
      valid_q <= cyc_valid_i;
      if (cyc_valid_i) begin
        dst_q     <= dst_d;
        int_sel_q <= int_sel;
        post_q    <= post_d;
        wrap_q    <= wrap_d;
        addr_q    <= cyc_addr_i;
      end else begin
        dst_q     <= '0;
        int_sel_q <= '0;
        post_q    <= 1'b0;
        wrap_q    <= 1'b0;
      end
    end
  end

  assign out_valid_o = valid_q;
  assign dst_o       = dst_q;
  assign int_sel_o   = int_sel_q;
  assign post_ok_o   = post_q;
  assign wrap_o      = wrap_q;
  assign addr_o      = addr_q;
endmodule

// File: rtl/io_rtr_chk.sv
module io_rtr_chk #(
  parameter logic [15:0] PM_ADDR = 16'h0022
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cyc_valid_i,
  input logic [15:0] cyc_addr_i,
  input logic [1:0]  cyc_size_i,
  input logic        cyc_write_i,
  input logic        out_valid_o,
  input logic [2:0]  dst_o,
  input logic [2:0]  int_sel_o,
  input logic        post_ok_o,
  input logic        wrap_o,
  input logic [15:0] addr_o
);
  p_lat_on_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_i |=> out_valid_o);
  p_lat_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_valid_i |=> !out_valid_o);
  p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $countones(dst_o) == 1);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> (dst_o == 3'b000 && int_sel_o == 3'b000 && !post_ok_o));
  p_int_sel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (dst_o[0] ? $countones(int_sel_o) == 1 : int_sel_o == 3'b000));
  p_cfa_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_valid_i && cyc_addr_i >= 16'h0CF8 && cyc_addr_i <= 16'h0CFB)
      |=> (dst_o == 3'b001 && int_sel_o == 3'b001));
  p_pm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_valid_i && cyc_addr_i == PM_ADDR) |=> (dst_o == 3'b001 && int_sel_o == 3'b100));
  p_wrap2_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_valid_i && cyc_size_i == 2'd1 && cyc_addr_i == 16'hFFFF) |=> wrap_o);
  p_nowrap1_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_valid_i && cyc_size_i == 2'd0) |=> !wrap_o);
  p_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_i |=> addr_o == $past(cyc_addr_i));
  p_read_nopost_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_valid_i && !cyc_write_i) |=> !post_ok_o);
  p_int_nopost_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && dst_o[0]) |-> !post_ok_o);
endmodule

bind io_cycle_router io_rtr_chk #(.PM_ADDR(PM_ADDR)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cyc_valid_i (cyc_valid_i),
  .cyc_addr_i  (cyc_addr_i),
  .cyc_size_i  (cyc_size_i),
  .cyc_write_i (cyc_write_i),
  .out_valid_o (out_valid_o),
  .dst_o       (dst_o),
  .int_sel_o   (int_sel_o),
  .post_ok_o   (post_ok_o),
  .wrap_o      (wrap_o),
  .addr_o      (addr_o)
);

// File: tb/test_io_cycle_router.sv
module test_io_cycle_router;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cyc_valid, cyc_write, cyc_msb;
  logic [15:0] cyc_addr;
  logic [1:0]  cyc_size;
  logic        win_we, win_sel;
  logic [15:0] win_data;
  logic        out_valid, post_ok, wrap;
  logic [2:0]  dst, int_sel;
  logic [15:0] addr_out;

  typedef struct {
    logic [2:0]  dst;
    logic [2:0]  isel;
    logic        post;
    logic        wrap;
    logic [15:0] addr;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  // bench model state
  logic        m_en = 1'b0;
  logic [15:0] m_base = 16'hFFFF, m_limit = 16'h0000;

  always #4 clk = ~clk;

  io_cycle_router i_io_cycle_router (
    .clk_i(clk), .rst_ni(rst_n),
    .cyc_valid_i(cyc_valid), .cyc_addr_i(cyc_addr), .cyc_size_i(cyc_size),
    .cyc_write_i(cyc_write), .cyc_wdata_msb_i(cyc_msb),
    .win_we_i(win_we), .win_sel_i(win_sel), .win_data_i(win_data),
    .out_valid_o(out_valid), .dst_o(dst), .int_sel_o(int_sel),
    .post_ok_o(post_ok), .wrap_o(wrap), .addr_o(addr_out)
  );

  function automatic exp_t model(input logic [15:0] a, input logic [1:0] sz,
                                 input logic wr, input string tag);
    exp_t e;
    logic cfa, cfd, pm, intl, gfx, ide;
    cfa = (a >= 16'h0CF8) && (a <= 16'h0CFB);
    cfd = m_en && (a >= 16'h0CFC) && (a <= 16'h0CFF);
    pm  = (a == 16'h0022);
    intl = cfa || cfd || pm;
    gfx = !intl && (m_base <= a) && (a <= m_limit);
    ide = (a >= 16'h01F0 && a <= 16'h01F7) || a == 16'h03F6 ||
          (a >= 16'h0170 && a <= 16'h0177) || a == 16'h0376;
    e.dst  = {gfx, !intl && !gfx, intl};
    e.isel = {pm, cfd, cfa};
    e.post = wr && !intl && !ide;
    e.wrap = (sz == 2'd1 && a == 16'hFFFF) || (sz[1] && a >= 16'hFFFD);
    e.addr = a;
    e.tag  = tag;
    return e;
  endfunction

  task automatic cyc(input logic [15:0] a, input logic [1:0] sz, input logic wr,
                     input logic msb, input string tag);
    @(negedge clk);
    cyc_valid = 1'b1; cyc_addr = a; cyc_size = sz; cyc_write = wr; cyc_msb = msb;
    win_we = 1'b0;
    q.push_back(model(a, sz, wr, tag));
    if (wr && a == 16'h0CF8 && sz[1]) m_en = msb;
  endtask

  task automatic gap();
    @(negedge clk);
    cyc_valid = 1'b0; win_we = 1'b0;
  endtask

  task automatic set_win(input logic [15:0] b, input logic [15:0] l);
    @(negedge clk);
    cyc_valid = 1'b0; win_we = 1'b1; win_sel = 1'b0; win_data = b;
    @(negedge clk);
    win_sel = 1'b1; win_data = l;
    @(negedge clk);
    win_we = 1'b0;
    m_base = b; m_limit = l;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        n_chk++;
        if (q.size() == 0) begin
          n_bad++;
          $display("FAIL R2: unexpected result, actual out_valid=1 expected out_valid=0");
        end else begin
          exp_t e;
          e = q.pop_front();
          if (dst !== e.dst || int_sel !== e.isel || post_ok !== e.post ||
              wrap !== e.wrap || addr_out !== e.addr) begin
            n_bad++;
            $display("FAIL %s: addr=%h actual dst=%b isel=%b post=%b wrap=%b a=%h expected dst=%b isel=%b post=%b wrap=%b a=%h",
                     e.tag, e.addr, dst, int_sel, post_ok, wrap, addr_out,
                     e.dst, e.isel, e.post, e.wrap, e.addr);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R2: watchdog expired, actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; cyc_valid = 1'b0; cyc_addr = '0; cyc_size = '0;
    cyc_write = 1'b0; cyc_msb = 1'b0; win_we = 1'b0; win_sel = 1'b0; win_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || dst !== 3'b000 || int_sel !== 3'b000 || post_ok !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: reset state actual v=%b dst=%b isel=%b post=%b expected 0/000/000/0",
               out_valid, dst, int_sel, post_ok);
    end

    // R1 empty window after reset, R7 PCI default
    cyc(16'hFFFF, 2'd0, 1'b0, 1'b0, "R1");
    cyc(16'h0000, 2'd0, 1'b0, 1'b0, "R1");
    cyc(16'h0080, 2'd0, 1'b1, 1'b0, "R7");
    gap();

    // R3 / R4 config address and data window
    cyc(16'h0CFC, 2'd2, 1'b0, 1'b0, "R4");
    cyc(16'h0CF8, 2'd2, 1'b1, 1'b1, "R3");
    cyc(16'h0CFC, 2'd2, 1'b0, 1'b0, "R4");
    cyc(16'h0CFF, 2'd0, 1'b1, 1'b0, "R4");
    cyc(16'h0CFB, 2'd0, 1'b0, 1'b0, "R3");
    cyc(16'h0CF8, 2'd1, 1'b1, 1'b0, "R3");
    cyc(16'h0CFE, 2'd1, 1'b0, 1'b0, "R4");
    cyc(16'h0CF8, 2'd2, 1'b1, 1'b0, "R3");
    cyc(16'h0CFD, 2'd0, 1'b1, 1'b0, "R4");
    cyc(16'h0D00, 2'd0, 1'b0, 1'b0, "R7");
    gap();

    // R5 power management register
    cyc(16'h0022, 2'd0, 1'b1, 1'b0, "R5");
    cyc(16'h0022, 2'd0, 1'b0, 1'b0, "R5");
    cyc(16'h0023, 2'd0, 1'b1, 1'b0, "R7");
    gap();

    // R6 inclusive window bounds
    set_win(16'h1000, 16'h10FF);
    cyc(16'h1000, 2'd0, 1'b0, 1'b0, "R6");
    cyc(16'h10FF, 2'd0, 1'b0, 1'b0, "R6");
    cyc(16'h0FFF, 2'd0, 1'b0, 1'b0, "R6");
    cyc(16'h1100, 2'd0, 1'b0, 1'b0, "R6");
    cyc(16'h1050, 2'd2, 1'b1, 1'b0, "R9");
    gap();

    // R9 no posting to disk controller ranges
    cyc(16'h01F0, 2'd0, 1'b1, 1'b0, "R9");
    cyc(16'h01F7, 2'd0, 1'b1, 1'b0, "R9");
    cyc(16'h01EF, 2'd0, 1'b1, 1'b0, "R9");
    cyc(16'h01F8, 2'd0, 1'b1, 1'b0, "R9");
    cyc(16'h03F6, 2'd0, 1'b1, 1'b0, "R9");
    cyc(16'h03F7, 2'd0, 1'b1, 1'b0, "R9");
    cyc(16'h0170, 2'd1, 1'b1, 1'b0, "R9");
    cyc(16'h0177, 2'd0, 1'b1, 1'b0, "R9");
    cyc(16'h0178, 2'd0, 1'b1, 1'b0, "R9");
    cyc(16'h0376, 2'd0, 1'b1, 1'b0, "R9");
    cyc(16'h0375, 2'd0, 1'b1, 1'b0, "R9");
    gap();

    // R8 wrap past FFFFh
    cyc(16'hFFFD, 2'd2, 1'b0, 1'b0, "R8");
    cyc(16'hFFFE, 2'd3, 1'b0, 1'b0, "R8");
    cyc(16'hFFFF, 2'd2, 1'b1, 1'b0, "R8");
    cyc(16'hFFFC, 2'd2, 1'b0, 1'b0, "R8");
    cyc(16'hFFFF, 2'd1, 1'b0, 1'b0, "R8");
    cyc(16'hFFFE, 2'd1, 1'b0, 1'b0, "R8");
    cyc(16'hFFFF, 2'd0, 1'b0, 1'b0, "R8");
    cyc(16'h1234, 2'd2, 1'b0, 1'b0, "R8");
    gap();

    // R10 internal priority over window
    set_win(16'h0000, 16'hFFFF);
    cyc(16'h0CF8, 2'd2, 1'b1, 1'b1, "R10");
    cyc(16'h0CFC, 2'd2, 1'b1, 1'b0, "R10");
    cyc(16'h0022, 2'd0, 1'b0, 1'b0, "R10");
    cyc(16'h0D00, 2'd0, 1'b1, 1'b0, "R10");
    cyc(16'hFFFF, 2'd1, 1'b1, 1'b0, "R10");
    gap();

    // R6 base above limit disables
    set_win(16'h2000, 16'h1FFF);
    cyc(16'h2000, 2'd0, 1'b0, 1'b0, "R6");
    cyc(16'h1FFF, 2'd0, 1'b0, 1'b0, "R6");
    set_win(16'h3000, 16'h3000);
    cyc(16'h3000, 2'd0, 1'b0, 1'b0, "R6");
    cyc(16'h3001, 2'd0, 1'b0, 1'b0, "R6");
    gap();
    repeat (4) @(negedge clk);

    n_chk++;
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL R2: results missing, actual pending=%0d expected 0", q.size());
    end
    done = 1'b1;
    summary();
  end
endmodule